// File: doc/BRIEF.md
# Multiplier result interlock controller

This block lives in the decode stage of an in-order scalar pipeline that shares one multi-cycle multiplier. Each cycle it looks at the decode flags of the waiting instruction: its multiplier class, which source registers it reads and which register it writes. It keeps a small record of the multiplier work already under way. From these it raises a stall, and the decode stage holds its instruction and sends bubbles until the stall drops.

The record is a set of down-counters, each reloaded when an instruction issues (valid and not stalled) and otherwise counting down to zero:
- the remaining result time of a general-register multiply, together with its destination register;
- the remaining result time of the accumulator pair;
- the remaining multiplier lock;
- the issue interval that a following multiply-accumulate has to respect.

How long an instruction waits depends on what kind of consumer it is:
- A reader of a multiplied general register waits the full latency.
- A move out of the accumulator waits one cycle less.
- A multiply-accumulate ignores the accumulator result hazard.
- When the multiplier is locked, a multiply-accumulate waits only the short issue interval, while any other multiplier instruction waits for the lock to clear.

Top module: `mult_hazard_ctl`

## Requirements
- R1: In the cycle after synchronous active-high reset, the stall output is low whatever instruction is presented, because all tracking state has been cleared.
- R2: An instruction whose enabled source (a or b) equals the destination of a general-register multiply (class code 1) that issued in the previous cycle is stalled for exactly LAT cycles (default 3).
- R3: An accumulator-read instruction (class code 4) that directly follows an accumulator multiply (class code 2) is stalled for exactly LAT-1 cycles (default 2). The same holds after a multiply-accumulate (class code 3).
- R4: A multiply-accumulate (class code 3) is never held by the accumulator result hazard. Directly after another multiply-accumulate or after an accumulator multiply, it waits exactly MAC_GAP cycles (default 2), even when the lock lasts longer.
- R5: A plain multiply (class code 1 or 2) that directly follows a plain multiply is stalled for exactly LOCK_MUL cycles (default 2).
- R6: A plain multiply that directly follows a multiply-accumulate is stalled for exactly MAC_MA+MAC_MM cycles (default 4), which is the full lock of the multiply-accumulate.
- R7: The stall is a same-cycle function of the decode inputs and the tracking state. When several hazards apply at once, the stall holds until the last of them has cleared, and no stall lasts longer than the longest single wait.
- R8: An instruction of class code 0 stalls only when an enabled source matches a pending general-register destination. A source whose enable bit is low is ignored, even when its register number matches.
- R9: While the decode valid input is low, stall stays low and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is waiting in decode |
| dec_class | input | 3 | Class code: 0 other, 1 multiply to general register, 2 multiply to accumulator, 3 multiply-accumulate, 4 accumulator read |
| src_a | input | REG_W | First source register number |
| src_a_en | input | 1 | First source is read |
| src_b | input | REG_W | Second source register number |
| src_b_en | input | 1 | Second source is read |
| dst_reg | input | REG_W | Destination register of a class-1 multiply |
| stall | output | 1 | Hold the decode instruction this cycle |

## Verification
The bench builds the block with its default parameters: LAT 3, LOCK_MUL 2, two memory-access cycles and two multiplier cycles for a multiply-accumulate, MAC_GAP 2, and 16 registers. These values are large enough for the lock of a multiply-accumulate to outlast its issue interval, so the short MAC wait can be told apart from the full unlock. They also leave a result pending when the lock of a plain multiply has already ended, so back-to-back multiplies with overlapping records occur. In the random phase the register numbers are drawn from only four values, which makes source matches against the pending destination frequent.

// File: rtl/mhi_pkg.sv
package mhi_pkg;

  typedef enum logic [2:0] {
    MC_NONE    = 3'd0,
    MC_MUL_GPR = 3'd1,
    MC_MUL_ACC = 3'd2,
    MC_MAC     = 3'd3,
    MC_ACC_RD  = 3'd4
  } mclass_e;

  function automatic int mhi_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // True for any class that occupies the multiplier.
  function automatic logic uses_mult(input mclass_e c);
    return (c == MC_MUL_GPR) || (c == MC_MUL_ACC) || (c == MC_MAC);
  endfunction

  // True for a class that writes the accumulator pair.
  function automatic logic writes_acc(input mclass_e c);
    return (c == MC_MUL_ACC) || (c == MC_MAC);
  endfunction

  // Lock cycles that an issuing multiplier instruction imposes.
  function automatic int lock_len(input mclass_e c, input int plain_lock, input int mac_lock);
    return (c == MC_MAC) ? mac_lock : plain_lock;
  endfunction

  // An accumulator reader waits one cycle less than the result time.
  function automatic logic acc_still_busy(input int remaining);
    return remaining > 1;
  endfunction

endpackage

// File: rtl/mhi_countdown.sv
module mhi_countdown #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/mhi_dest_record.sv
module mhi_dest_record #(
  parameter int REG_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] load_reg,
  input  logic [CNT_W-1:0] load_cnt,
  output logic [REG_W-1:0] rec_reg,
  output logic [CNT_W-1:0] rec_cnt,
  output logic             rec_live
);

  mhi_countdown #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_cnt),
    .cnt      (rec_cnt)
  );

  // The register number is dropped as soon as the count expires.
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_reg <= '0;
    end else if (load) begin
      rec_reg <= load_reg;
    end else if (rec_cnt <= CNT_W'(1)) begin
      rec_reg <= '0;
    end
  end

  assign rec_live = (rec_cnt != '0);

endmodule

// File: rtl/mhi_hazard_eval.sv
module mhi_hazard_eval
  import mhi_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             valid,
  input  mclass_e          cls,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_a_en,
  input  logic [REG_W-1:0] src_b,
  input  logic             src_b_en,
  input  logic             gpr_live,
  input  logic [REG_W-1:0] gpr_reg,
  input  logic [CNT_W-1:0] acc_cnt,
  input  logic [CNT_W-1:0] lock_cnt,
  input  logic [CNT_W-1:0] gap_cnt,
  output logic             haz_gpr,
  output logic             haz_acc,
  output logic             haz_lock,
  output logic             haz_mac,
  output logic             stall
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            src_en;
  logic [NSRC-1:0]            src_hit;

  assign srcs   = {src_b, src_a};
  assign src_en = {src_b_en, src_a_en};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_hit[i] = src_en[i] && gpr_live && (srcs[i] == gpr_reg);
  end

  always_comb begin
    haz_gpr  = valid && (|src_hit);
    haz_acc  = valid && (cls == MC_ACC_RD) && acc_still_busy(int'(acc_cnt));
    haz_lock = valid && uses_mult(cls) && (cls != MC_MAC) && (lock_cnt != '0);
    haz_mac  = valid && (cls == MC_MAC) && (lock_cnt != '0) && (gap_cnt != '0);
    stall    = haz_gpr || haz_acc || haz_lock || haz_mac;
  end

endmodule

// File: rtl/mult_hazard_ctl.sv
module mult_hazard_ctl
  import mhi_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int LAT      = 3,
  parameter int LOCK_MUL = 2,
  parameter int MAC_MA   = 2,
  parameter int MAC_MM   = 2,
  parameter int MAC_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [2:0]       dec_class,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_a_en,
  input  logic [REG_W-1:0] src_b,
  input  logic             src_b_en,
  input  logic [REG_W-1:0] dst_reg,
  output logic             stall
);

  localparam int MAC_LOCK = MAC_MA + MAC_MM;
  localparam int MAX_WAIT = mhi_max(mhi_max(LAT, LOCK_MUL), mhi_max(MAC_LOCK, MAC_GAP));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  mclass_e          cls;
  logic             issue;
  logic             ld_gpr, ld_acc, ld_lock;
  logic [CNT_W-1:0] lock_val;
  logic [REG_W-1:0] gpr_reg;
  logic [CNT_W-1:0] gpr_cnt, acc_cnt, lock_cnt, gap_cnt;
  logic             gpr_live;
  logic             haz_gpr, haz_acc, haz_lock, haz_mac;

  assign cls      = mclass_e'(dec_class);
  assign issue    = dec_valid && !stall;
  assign ld_gpr   = issue && (cls == MC_MUL_GPR);
  assign ld_acc   = issue && writes_acc(cls);
  assign ld_lock  = issue && uses_mult(cls);
  assign lock_val = CNT_W'(lock_len(cls, LOCK_MUL, MAC_LOCK));

  mhi_dest_record #(.REG_W(REG_W), .CNT_W(CNT_W)) u_gpr_rec (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_gpr),
    .load_reg (dst_reg),
    .load_cnt (CNT_W'(LAT)),
    .rec_reg  (gpr_reg),
    .rec_cnt  (gpr_cnt),
    .rec_live (gpr_live)
  );

  mhi_countdown #(.W(CNT_W)) u_acc_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_acc),
    .load_val (CNT_W'(LAT)),
    .cnt      (acc_cnt)
  );

  mhi_countdown #(.W(CNT_W)) u_lock_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_lock),
    .load_val (lock_val),
    .cnt      (lock_cnt)
  );

  mhi_countdown #(.W(CNT_W)) u_gap_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_lock),
    .load_val (CNT_W'(MAC_GAP)),
    .cnt      (gap_cnt)
  );

  mhi_hazard_eval #(.REG_W(REG_W), .CNT_W(CNT_W)) u_eval (
    .valid    (dec_valid),
    .cls      (cls),
    .src_a    (src_a),
    .src_a_en (src_a_en),
    .src_b    (src_b),
    .src_b_en (src_b_en),
    .gpr_live (gpr_live),
    .gpr_reg  (gpr_reg),
    .acc_cnt  (acc_cnt),
    .lock_cnt (lock_cnt),
    .gap_cnt  (gap_cnt),
    .haz_gpr  (haz_gpr),
    .haz_acc  (haz_acc),
    .haz_lock (haz_lock),
    .haz_mac  (haz_mac),
    .stall    (stall)
  );

endmodule

// File: rtl/mult_hazard_ctl_chk.sv
module mult_hazard_ctl_chk #(
  parameter int REG_W    = 4,
  parameter int MAX_WAIT = 4,
  parameter int MAC_GAP  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic [2:0]       dec_class,
  input logic [REG_W-1:0] src_a,
  input logic             src_a_en,
  input logic             src_b_en,
  input logic [REG_W-1:0] dst_reg,
  input logic             issue,
  input logic             haz_mac,
  input logic             stall
);

  logic [7:0] stall_run;
  logic [7:0] mac_run;
  logic       plain_mac;

  assign plain_mac = dec_valid && (dec_class == 3'd3) && !src_a_en && !src_b_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_run <= '0;
      mac_run   <= '0;
    end else begin
      stall_run <= stall ? ((stall_run == 8'hFF) ? stall_run : stall_run + 1'b1) : '0;
      mac_run   <= (stall && plain_mac) ? ((mac_run == 8'hFF) ? mac_run : mac_run + 1'b1) : '0;
    end
  end

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !stall);

  a_r8_free_issue: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == 3'd0 && !src_a_en && !src_b_en) |-> !stall);

  a_r2_gpr_wait: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == 3'd1) ##1 (dec_valid && src_a_en && src_a == $past(dst_reg)) |-> stall);

  a_r3_acc_wait: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_class == 3'd2) ##1 (dec_valid && dec_class == 3'd4) |-> stall);

  a_r5_lock_wait: assert property (@(posedge clk) disable iff (rst)
    (issue && (dec_class == 3'd1 || dec_class == 3'd2)) ##1
    (dec_valid && (dec_class == 3'd1 || dec_class == 3'd2)) |-> stall);

  a_r4_mac_gap_only: assert property (@(posedge clk) disable iff (rst)
    (stall && plain_mac) |-> (int'(mac_run) < MAC_GAP) && haz_mac);

  a_r7_bounded_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> int'(stall_run) < MAX_WAIT);

endmodule

bind mult_hazard_ctl mult_hazard_ctl_chk #(
  .REG_W    (REG_W),
  .MAX_WAIT (MAX_WAIT),
  .MAC_GAP  (MAC_GAP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_valid (dec_valid),
  .dec_class (dec_class),
  .src_a     (src_a),
  .src_a_en  (src_a_en),
  .src_b_en  (src_b_en),
  .dst_reg   (dst_reg),
  .issue     (issue),
  .haz_mac   (haz_mac),
  .stall     (stall)
);

// File: tb/mult_hazard_ctl_tb.sv
`timescale 1ns/1ps
module mult_hazard_ctl_tb;

  localparam int REG_W = 4, LAT = 3, LOCK_MUL = 2, MAC_MA = 2, MAC_MM = 2, MAC_GAP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic [2:0] dec_class = 3'd0;
  logic [REG_W-1:0] src_a = '0, src_b = '0, dst_reg = '0;
  logic src_a_en = 1'b0, src_b_en = 1'b0;
  logic stall;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state, in plain integers
  int gpr_rem = 0, gpr_reg = 0, acc_rem = 0, lock_rem = 0, gap_rem = 0;

  always #10 clk = ~clk;

  mult_hazard_ctl #(.REG_W(REG_W), .LAT(LAT), .LOCK_MUL(LOCK_MUL),
                    .MAC_MA(MAC_MA), .MAC_MM(MAC_MM), .MAC_GAP(MAC_GAP)) u_dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .src_a(src_a), .src_a_en(src_a_en), .src_b(src_b), .src_b_en(src_b_en),
    .dst_reg(dst_reg), .stall(stall));

  function automatic bit model_stall(bit v, int c, int sa, bit ua, int sb, bit ub);
    bit s = 0;
    if (!v) return 0;
    if (gpr_rem > 0 && ((ua && sa == gpr_reg) || (ub && sb == gpr_reg))) s = 1;
    if (c == 4 && acc_rem >= 2) s = 1;
    if ((c == 1 || c == 2) && lock_rem > 0) s = 1;
    if (c == 3 && lock_rem > 0 && gap_rem > 0) s = 1;
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one decode cycle: drive, compare against the model, then advance the model
  task automatic step(input bit v, input int c, input int sa, input bit ua,
                      input int sb, input bit ub, input int dr, output bit st);
    bit exp;
    @(negedge clk);
    dec_valid = v; dec_class = 3'(c);
    src_a = REG_W'(sa); src_a_en = ua; src_b = REG_W'(sb); src_b_en = ub;
    dst_reg = REG_W'(dr);
    #5;
    exp = model_stall(v, c, sa, ua, sb, ub);
    check(stall === exp, "R7 per-cycle stall", int'(stall), int'(exp));
    st = stall;
    if (gpr_rem > 0) gpr_rem--;
    if (acc_rem > 0) acc_rem--;
    if (lock_rem > 0) lock_rem--;
    if (gap_rem > 0) gap_rem--;
    if (v && !exp) begin
      if (c == 1) begin gpr_rem = LAT; gpr_reg = dr; end
      if (c == 2 || c == 3) acc_rem = LAT;
      if (c >= 1 && c <= 3) begin
        lock_rem = (c == 3) ? MAC_MA + MAC_MM : LOCK_MUL;
        gap_rem  = MAC_GAP;
      end
    end
  endtask

  // hold one instruction in decode until it issues; return the stall count
  task automatic hold_until_issue(input int c, input int sa, input bit ua,
                                  input int sb, input bit ub, input int dr, output int n);
    bit st;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      step(1, c, sa, ua, sb, ub, dr, st);
      if (!st) break;
      n++;
    end
  endtask

  task automatic pair(input int c1, input int dr1, input int c2, input int sa, input bit ua,
                      input int sb, input bit ub, input int expw, input string req);
    int n;
    hold_until_issue(c1, 0, 0, 0, 0, dr1, n);
    hold_until_issue(c2, sa, ua, sb, ub, 0, n);
    check(n == expw, req, n, expw);
    repeat (6) begin bit st; step(0, 0, 0, 0, 0, 0, 0, st); end
  endtask

  initial begin
    bit st;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: nothing pending after reset
    step(1, 4, 0, 0, 0, 0, 0, st);
    check(st == 0, "R1 acc read after reset", st, 0);
    step(1, 0, 0, 1, 0, 1, 0, st);
    check(st == 0, "R1 reg read after reset", st, 0);
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, st);

    pair(1, 5, 0, 0, 0, 5, 1, LAT,     "R2 reader via src b");
    pair(1, 7, 0, 7, 1, 0, 0, LAT,     "R2 reader via src a");
    pair(2, 0, 4, 0, 0, 0, 0, LAT - 1, "R3 acc read after acc multiply");
    pair(3, 0, 4, 0, 0, 0, 0, LAT - 1, "R3 acc read after mac");
    pair(3, 0, 3, 0, 0, 0, 0, MAC_GAP, "R4 mac after mac");
    pair(2, 0, 3, 0, 0, 0, 0, MAC_GAP, "R4 mac after acc multiply");
    pair(1, 3, 2, 0, 0, 0, 0, LOCK_MUL, "R5 multiply after multiply");
    pair(3, 0, 1, 0, 0, 0, 0, MAC_MA + MAC_MM, "R6 multiply after mac");
    pair(1, 5, 0, 6, 1, 5, 0, 0,       "R8 disabled source ignored");
    pair(1, 5, 0, 2, 1, 9, 1, 0,       "R8 unrelated sources");
    pair(1, 2, 1, 2, 1, 0, 0, LAT,     "R7 lock and result combined");

    // R9: valid low hides a matching source
    hold_until_issue(1, 0, 0, 0, 0, 4, n);
    step(0, 0, 4, 1, 4, 1, 0, st);
    check(st == 0, "R9 idle with matching source", st, 0);
    step(0, 1, 0, 0, 0, 0, 0, st);
    check(st == 0, "R9 idle multiply class", st, 0);
    hold_until_issue(0, 4, 1, 0, 0, 0, n);
    check(n == LAT - 2, "R9 result still tracked", n, LAT - 2);

    // random traffic, compared every cycle inside step
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4),
           $urandom_range(0, 3), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3), st);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule